// File: doc/BRIEF.md
# Serial Receive Line Break Detector

This block watches an already-synchronized serial receive line and recognises a line break: the line held low without interruption for longer than a selectable number of character times. It advances only on a 16x-baud oversample tick enable, so every duration it measures is a count of tick-qualified samples. One oversampled bit-time is 16 ticks. A character time is 10 bit-times, or 11 when a parity bit is part of the frame.

The block has two outputs. The first is a level status that stays high while a break is in progress. The second is a single-cycle event pulse meant for an interrupt controller. A break gives exactly one event, however long the line stays low. The detector re-arms only after the line has been sampled high for half a bit-time (8 consecutive ticks). Shorter high blips restart the low-time measurement but leave the status set and do not re-arm the event.

Top module: `brk_watch`

## Requirements
- R1: The 2-bit level select picks the threshold in character times: code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 16.
- R2: The threshold in ticks is chars × bits × 16, where bits is 10 with parity disabled and 11 with parity enabled. The status rises on the clock edge that samples the (threshold+1)-th consecutive low tick. It stays low after exactly threshold low ticks.
- R3: Only cycles with the tick enable high sample the line. Cycles without a tick change neither the low-time measurement nor the status.
- R4: Any tick sample with the line high restarts the low-time measurement from zero.
- R5: The event output is high for exactly one cycle, on the same edge where the status rises. A break that continues produces no further event.
- R6: Once set, the status stays high through high runs shorter than 8 consecutive ticks. It clears on the edge that samples the 8th consecutive high tick. No new event is possible until it has cleared.
- R7: The low-time counter saturates instead of wrapping, so the status stays high with no extra event for a low period of any length.
- R8: While reset is asserted, the status and event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronized serial receive line, idle high |
| tick16_i | input | 1 | Oversample enable, 16 per bit-time |
| parity_en_i | input | 1 | 1 when frames carry a parity bit (11-bit characters) |
| level_sel_i | input | 2 | Break threshold select (0:2, 1:4, 2:8, 3:16 characters) |
| break_o | output | 1 | Break in progress |
| break_evt_o | output | 1 | One-cycle pulse when a break is first recognised |

## Verification
The bound checker verifies on every cycle the relations between the two outputs and the sampled line:
- The event lasts one cycle, coincides with a status rise, and never occurs without one.
- The status rises only after a low tick sample and falls only after a high tick sample.
- The status never changes on a cycle with no tick.

The exact threshold, measured in ticks for each of the eight select and parity combinations, can only be shown by the bench's sweeps. The same is true of the restart on a single high blip, the 8-tick re-arm boundary, and the absence of wrap-around during a very long break.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic {
    BRK_ARMED   = 1'b0,
    BRK_ACTIVE  = 1'b1
  } brk_state_e;

  // Character time in bit-times: start + data + stop, plus parity if enabled
  function automatic int unsigned char_bits(input int unsigned data_bits,
                                            input int unsigned par);
    return data_bits + 2 + par;
  endfunction

  // Characters of low time selected by a level code: 2, 4, 8, 16, ...
  function automatic int unsigned level_chars(input int unsigned code);
    return 32'd2 << code;
  endfunction

endpackage

// File: rtl/brk_thresh.sv
module brk_thresh #(
  parameter int unsigned OSR       = 16,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned CNT_W     = 12
) (
  input  logic             parity_en_i,
  input  logic [SEL_W-1:0] level_sel_i,
  output logic [CNT_W-1:0] thr_o
);
  import brk_pkg::*;

  localparam int unsigned NLVL = 1 << SEL_W;

  logic [CNT_W-1:0] thr_nopar [NLVL];
  logic [CNT_W-1:0] thr_par   [NLVL];

  // One constant threshold per select code and parity setting
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign thr_nopar[g] = CNT_W'(level_chars(g) * char_bits(DATA_BITS, 0) * OSR);
    assign thr_par[g]   = CNT_W'(level_chars(g) * char_bits(DATA_BITS, 1) * OSR);
  end

  always_comb begin
    if (parity_en_i) thr_o = thr_par[level_sel_i];
    else             thr_o = thr_nopar[level_sel_i];
  end

endmodule

// File: rtl/brk_run_cnt.sv
module brk_run_cnt #(
  parameter int unsigned W     = 4,
  parameter int unsigned LIMIT = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hit_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  // Length of the current run of matching samples, held at LIM
  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (!hit_i)           cnt_d = '0;
      else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned HI_W  = 4,
  parameter int unsigned REARM = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [HI_W-1:0]  hi_cnt_i,
  output logic             break_o,
  output logic             evt_o
);
  import brk_pkg::*;

  localparam logic [HI_W-1:0] HI_LAST = HI_W'(REARM - 1);

  brk_state_e state_q, state_d;
  logic       evt_q, evt_d;
  logic       low_over, high_done;

  // low_cnt_i is the run length before this sample; this sample is one more
  assign low_over  = tick_i && !rx_i && (low_cnt_i >= thr_i);
  assign high_done = tick_i &&  rx_i && (hi_cnt_i == HI_LAST);

  always_comb begin
    state_d = state_q;
    evt_d   = 1'b0;
    unique case (state_q)
      BRK_ARMED: begin
        if (low_over) begin
          state_d = BRK_ACTIVE;
          evt_d   = 1'b1;
        end
      end
      BRK_ACTIVE: begin
        if (high_done) state_d = BRK_ARMED;
      end
      default: state_d = BRK_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BRK_ARMED;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= evt_d;
    end
  end

  assign break_o = (state_q == BRK_ACTIVE);
  assign evt_o   = evt_q;

endmodule

// File: rtl/brk_watch.sv
module brk_watch #(
  parameter int unsigned OSR       = 16,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             tick16_i,
  input  logic             parity_en_i,
  input  logic [SEL_W-1:0] level_sel_i,
  output logic             break_o,
  output logic             break_evt_o
);
  import brk_pkg::*;

  localparam int unsigned MAX_THR = level_chars((1 << SEL_W) - 1)
                                    * char_bits(DATA_BITS, 1) * OSR;
  localparam int unsigned CNT_W   = $clog2(MAX_THR + 2);
  localparam int unsigned LOW_SAT = (1 << CNT_W) - 1;
  localparam int unsigned REARM   = OSR / 2;
  localparam int unsigned HI_W    = $clog2(REARM + 1);

  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] low_cnt;
  logic [HI_W-1:0]  hi_cnt;

  brk_thresh #(
    .OSR       (OSR),
    .DATA_BITS (DATA_BITS),
    .SEL_W     (SEL_W),
    .CNT_W     (CNT_W)
  ) u_thresh (
    .parity_en_i (parity_en_i),
    .level_sel_i (level_sel_i),
    .thr_o       (thr)
  );

  brk_run_cnt #(
    .W     (CNT_W),
    .LIMIT (LOW_SAT)
  ) u_low_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick16_i),
    .hit_i  (!rx_i),
    .cnt_o  (low_cnt)
  );

  brk_run_cnt #(
    .W     (HI_W),
    .LIMIT (REARM)
  ) u_high_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick16_i),
    .hit_i  (rx_i),
    .cnt_o  (hi_cnt)
  );

  brk_ctrl #(
    .CNT_W (CNT_W),
    .HI_W  (HI_W),
    .REARM (REARM)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .rx_i      (rx_i),
    .low_cnt_i (low_cnt),
    .thr_i     (thr),
    .hi_cnt_i  (hi_cnt),
    .break_o   (break_o),
    .evt_o     (break_evt_o)
  );

endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic tick16_i,
  input logic break_o,
  input logic break_evt_o
);

  // R5: event lasts a single cycle
  p_evt_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_evt_o |=> !break_evt_o);

  // R5: event only together with a status rise
  p_evt_with_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_evt_o |-> (break_o && !$past(break_o)));

  // R5: every status rise carries an event
  p_rise_has_evt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> break_evt_o);

  // R2: status rises only after a low tick sample
  p_rise_on_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> $past(tick16_i && !rx_i));

  // R6: status clears only after a high tick sample
  p_fall_on_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(break_o) |-> $past(tick16_i && rx_i));

  // R3: nothing changes on a cycle without a tick
  p_no_tick_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick16_i |=> $stable(break_o));

  // R8: outputs quiet in reset
  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r8: assert (!break_o && !break_evt_o);
    end
  end

endmodule

bind brk_watch brk_watch_chk u_brk_watch_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_i        (rx_i),
  .tick16_i    (tick16_i),
  .break_o     (break_o),
  .break_evt_o (break_evt_o)
);

// File: tb/brk_watch_test.sv
module brk_watch_test;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       rx_i;
  logic       tick16_i;
  logic       parity_en_i;
  logic [1:0] level_sel_i;
  logic       break_o;
  logic       break_evt_o;

  int checks = 0;
  int errors = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  brk_watch uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_i        (rx_i),
    .tick16_i    (tick16_i),
    .parity_en_i (parity_en_i),
    .level_sel_i (level_sel_i),
    .break_o     (break_o),
    .break_evt_o (break_evt_o)
  );

  function automatic int exp_thr(input int sel, input int par);
    return (2 << sel) * (10 + par) * 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic step(input logic line, input logic tk);
    rx_i     = line;
    tick16_i = tk;
    @(negedge clk_i);
    if (break_evt_o) evt_cnt++;
  endtask

  task automatic run(input logic line, input int n);
    for (int i = 0; i < n; i++) step(line, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0;
    int t;
    rst_ni = 1'b0;
    rx_i = 1'b0;
    tick16_i = 1'b1;
    parity_en_i = 1'b0;
    level_sel_i = 2'd0;
    repeat (4) @(negedge clk_i);
    chk("R8 status in reset", break_o, 0);
    chk("R8 event in reset", break_evt_o, 0);
    rx_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(1'b1, 10);

    // R1 R2 R5 R6: sweep every select code and parity setting
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        level_sel_i = 2'(s);
        parity_en_i = 1'(p);
        t = exp_thr(s, p);
        e0 = evt_cnt;
        run(1'b0, t);
        chk($sformatf("R1 R2 sel%0d par%0d no break at threshold", s, p), break_o, 0);
        run(1'b0, 1);
        chk($sformatf("R2 sel%0d par%0d break after threshold", s, p), break_o, 1);
        chk($sformatf("R5 sel%0d par%0d event with rise", s, p), break_evt_o, 1);
        run(1'b0, 40);
        chk($sformatf("R5 sel%0d par%0d one event", s, p), evt_cnt - e0, 1);
        run(1'b1, 7);
        chk($sformatf("R6 sel%0d par%0d held over 7 high", s, p), break_o, 1);
        run(1'b0, t + 5);
        chk($sformatf("R6 sel%0d par%0d no rearm event", s, p), evt_cnt - e0, 1);
        run(1'b1, 7);
        chk($sformatf("R6 sel%0d par%0d still set", s, p), break_o, 1);
        run(1'b1, 1);
        chk($sformatf("R6 sel%0d par%0d clears on 8th high", s, p), break_o, 0);
        run(1'b0, t + 1);
        chk($sformatf("R6 sel%0d par%0d new break event", s, p), evt_cnt - e0, 2);
        run(1'b1, 8);
        chk($sformatf("R6 sel%0d par%0d cleared", s, p), break_o, 0);
      end
    end

    // R3: no-tick cycles do not count
    level_sel_i = 2'd0;
    parity_en_i = 1'b0;
    t = exp_thr(0, 0);
    for (int i = 0; i < t; i++) begin
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
    end
    chk("R3 idle cycles not counted", break_o, 0);
    step(1'b0, 1'b1);
    chk("R3 break on counted tick", break_o, 1);
    // high level without ticks must not clear
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    chk("R3 high without tick keeps status", break_o, 1);
    run(1'b1, 8);
    chk("R3 cleared by ticked highs", break_o, 0);

    // R4: one high sample restarts the low count
    level_sel_i = 2'd1;
    parity_en_i = 1'b1;
    t = exp_thr(1, 1);
    run(1'b0, t);
    run(1'b1, 1);
    run(1'b0, t);
    chk("R4 restart after single high", break_o, 0);
    run(1'b0, 1);
    chk("R4 break after full fresh run", break_o, 1);
    run(1'b1, 8);

    // R7: very long break, counter must not wrap
    level_sel_i = 2'd3;
    parity_en_i = 1'b1;
    e0 = evt_cnt;
    run(1'b0, 4200);
    chk("R7 status held over long low", break_o, 1);
    chk("R7 single event over long low", evt_cnt - e0, 1);
    run(1'b1, 8);
    chk("R7 clears after long low", break_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule